// File: doc/BRIEF.md
# Clause 45 Management Register Slave

This block is the management slave of a multi-lane serial transceiver. An external station manager reaches it over a two-wire management bus made of a clock line (MDC) and a bidirectional data line (MDIO), using the IEEE 802.3 Clause 45 indirect-address frame format. MDC runs at no more than 2.5 MHz and has no phase relation to any datapath clock. The block therefore oversamples MDC and MDIO in its own core clock and acts on the edges it detects. A frame is only accepted when its 5-bit port field matches the strapped port address and its device field selects device 30, which holds the transceiver's control registers.

Within device 30 the slave provides four registers to the core. Register 1 is the control register, with a self-clearing software reset bit, a software power-down bit and four per-lane receiver power-down bits. Registers 5 and 6 hold the two coefficients of the transmit de-emphasis filter. Register 49 holds the output-swing code. Address frames load the register pointer. Write frames store data at the pointer. Plain reads return data and leave the pointer alone, and post-increment reads advance it after the data phase. During a read the block drives MDIO through a separate enable, so that the pad ring can build the open line. A management-enable input, held low by the surrounding controller during hardware reset or power-down, makes the block ignore the bus completely.

Top module: `mdio_c45_slave`

## Requirements
- R1: After reset the control register and both de-emphasis coefficients read 0x0000, the swing register reads 0x0492, and `mdio_oe` is low.
- R2: A frame is accepted only after at least 32 consecutive ones, counted on MDC rising edges, followed by the start pattern 0,0. Every field is sent MSB first: opcode (2 bits), port (5), device (5), turnaround (2), data (16). A frame with 31 preamble ones is ignored.
- R3: A frame whose port field differs from `port_addr`, or whose device field is not 30, changes no register and never drives MDIO.
- R4: Opcode 00 loads the 16-bit data field into the register pointer. Opcode 01 writes the data field into the register at the pointer. Registers 5 and 6 store any 16-bit value.
- R5: On a read (opcode 11) the slave leaves MDIO undriven during the first turnaround bit and drives 0 during the second. It then drives the 16 data bits MSB first, changing the line only after MDC falling edges. It releases the line after the last data bit, and the pointer is left unchanged.
- R6: A post-increment read (opcode 10) returns the same data as a read and then adds one to the pointer.
- R7: Reads of any address other than 1, 5, 6 and 49 return 0x0000, and writes to such addresses are discarded.
- R8: In control register 1 only bit 11 (software power-down) and bits 3:0 (per-lane receiver power-down) are stored from a write. All other bits read 0, except bit 15 during its single reset cycle.
- R9: Writing register 1 with bit 15 set restores all four registers to their R1 values within one core cycle, and bit 15 then reads back 0.
- R10: Register 49 accepts only the eight codes k × 0x0492 for k = 0..7 (0x0000 to 0x1FFE). A write of any other value is discarded.
- R11: While `mgmt_en` is low, frames are ignored, no register changes and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock used to oversample MDC and MDIO |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_en | input | 1 | Management enable; low blocks all bus activity |
| port_addr | input | 5 | Strapped port address, bit 4 is the MSB |
| mdc | input | 1 | Management clock from the station manager |
| mdio_in | input | 1 | Value seen on the shared data line |
| mdio_out | output | 1 | Value the slave drives on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| ctrl_word | output | 16 | Control register (reset, power-down, lane power-down bits) |
| deemph_tap0 | output | 16 | First de-emphasis coefficient (register 5) |
| deemph_tap1 | output | 16 | Second de-emphasis coefficient (register 6) |
| swing_code | output | 16 | Output-swing code (register 49) |

## Verification
The bench builds the block with its defaults: device 30, a 32-bit preamble threshold and a two-stage input synchronizer. It strap the port address to 0b10110 and runs MDC at twelve core cycles per bit. That period leaves several core cycles between each detected MDC edge and the next sample. With it the turnaround, the read data and the release can be checked bit by bit against the frame the bench has driven. The 31-against-40-ones preamble cases exercise the exact threshold, and the swing values on either side of a legal step, including 8 × 0x0492, exercise the code filter.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned OP_W       = 2;
  localparam int unsigned PRT_W      = 5;
  localparam int unsigned DEV_W      = 5;
  localparam int unsigned TA_W       = 2;
  localparam int unsigned HDR_BITS   = OP_W + PRT_W + DEV_W;
  localparam int unsigned FRAME_BITS = HDR_BITS + TA_W + WORD_W;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RDINC = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_FRAME = 2'd2
  } eng_e;

  localparam logic [WORD_W-1:0] RA_CTRL   = 16'd1;
  localparam logic [WORD_W-1:0] RA_TAP0   = 16'd5;
  localparam logic [WORD_W-1:0] RA_TAP1   = 16'd6;
  localparam logic [WORD_W-1:0] RA_SWING  = 16'd49;

  localparam logic [WORD_W-1:0] CTRL_WMASK = 16'h880F;
  localparam int unsigned       SRST_BIT   = 15;
  localparam int unsigned       SWING_STEP  = 16'h0492;
  localparam int unsigned       SWING_STEPS = 8;
  localparam logic [WORD_W-1:0] DEF_SWING  = WORD_W'(SWING_STEP);
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdc_fall,
  output logic mdio_bit
);
  logic [STAGES-1:0] mdc_pipe_q, mdc_pipe_n;
  logic [STAGES-1:0] dat_pipe_q, dat_pipe_n;
  logic              mdc_last_q, mdc_last_n;

  always_comb begin
    mdc_pipe_n = {mdc_pipe_q[STAGES-2:0], mdc_i};
    dat_pipe_n = {dat_pipe_q[STAGES-2:0], mdio_i};
    mdc_last_n = mdc_pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_pipe_q <= '0;
      dat_pipe_q <= '1;
      mdc_last_q <= 1'b0;
    end else begin
      mdc_pipe_q <= mdc_pipe_n;
      dat_pipe_q <= dat_pipe_n;
      mdc_last_q <= mdc_last_n;
    end
  end

  assign mdc_rise = mdc_pipe_q[STAGES-1] & ~mdc_last_q;
  assign mdc_fall = ~mdc_pipe_q[STAGES-1] & mdc_last_q;
  assign mdio_bit = dat_pipe_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_c45_pkg::*;
#(
  parameter int unsigned DEV_ADDR     = 30,
  parameter int unsigned PREAMBLE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_en,
  input  logic [PRT_W-1:0]  port_addr,
  input  logic              rise,
  input  logic              fall,
  input  logic              bit_in,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] reg_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_en,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int unsigned PRE_W  = $clog2(PREAMBLE_LEN + 1);
  localparam int unsigned CNT_W  = $clog2(FRAME_BITS + 1);
  localparam logic [PRE_W-1:0] PRE_MAX   = PRE_W'(PREAMBLE_LEN);
  localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] TA_DRV    = CNT_W'(HDR_BITS + 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);

  eng_e              state_q, state_n;
  logic [PRE_W-1:0]  ones_q, ones_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [OP_W-1:0]   op_q, op_n;
  logic              hit_q, hit_n;
  logic [WORD_W-1:0] addr_q, addr_n;
  logic [WORD_W-1:0] rd_q, rd_n;
  logic              oe_q, oe_n;
  logic              out_q, out_n;
  logic [WORD_W-1:0] word_in;

  assign word_in = {sh_q[WORD_W-2:0], bit_in};

  always_comb begin
    state_n = state_q;
    ones_n  = ones_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    op_n    = op_q;
    hit_n   = hit_q;
    addr_n  = addr_q;
    rd_n    = rd_q;
    oe_n    = oe_q;
    out_n   = out_q;
    wr_en   = 1'b0;
    if (!mgmt_en) begin
      state_n = ST_IDLE;
      ones_n  = '0;
      oe_n    = 1'b0;
      out_n   = 1'b0;
    end else if (rise) begin
      case (state_q)
        ST_IDLE: begin
          if (bit_in) begin
            if (ones_q != PRE_MAX) ones_n = ones_q + PRE_W'(1);
          end else if (ones_q == PRE_MAX) begin
            state_n = ST_START;
          end else begin
            ones_n = '0;
          end
        end
        ST_START: begin
          if (!bit_in) begin
            state_n = ST_FRAME;
            cnt_n   = '0;
            hit_n   = 1'b0;
          end else begin
            state_n = ST_IDLE;
            ones_n  = PRE_W'(1);
          end
        end
        ST_FRAME: begin
          sh_n  = word_in;
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q == OP_LAST) op_n = word_in[OP_W-1:0];
          if (cnt_q == HDR_LAST)
            hit_n = (word_in[PRT_W+DEV_W-1:DEV_W] == port_addr) &&
                    (word_in[DEV_W-1:0] == DEV_W'(DEV_ADDR));
          if (cnt_q == DATA_LAST) begin
            state_n = ST_IDLE;
            ones_n  = '0;
            if (hit_q) begin
              case (op_q)
                OP_ADDR:  addr_n = word_in;
                OP_WRITE: wr_en  = 1'b1;
                OP_RDINC: addr_n = addr_q + WORD_W'(1);
                default:  ;
              endcase
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end else if (fall) begin
      if (state_q == ST_FRAME && hit_q && op_q[1] && cnt_q >= TA_DRV) begin
        oe_n = 1'b1;
        if (cnt_q == TA_DRV) begin
          out_n = 1'b0;
          rd_n  = rd_data;
        end else begin
          out_n = rd_q[WORD_W-1];
          rd_n  = {rd_q[WORD_W-2:0], 1'b0};
        end
      end else begin
        oe_n  = 1'b0;
        out_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ones_q  <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      op_q    <= '0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      rd_q    <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ones_q  <= ones_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      op_q    <= op_n;
      hit_q   <= hit_n;
      addr_q  <= addr_n;
      rd_q    <= rd_n;
      oe_q    <= oe_n;
      out_q   <= out_n;
    end
  end

  assign reg_addr = addr_q;
  assign wr_data  = word_in;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;
endmodule

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
  import mdio_c45_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] tap0_q,
  output logic [WORD_W-1:0] tap1_q,
  output logic [WORD_W-1:0] swing_q
);
  logic [WORD_W-1:0]      ctrl_n, tap0_n, tap1_n, swing_n;
  logic [SWING_STEPS-1:0] code_hit;
  logic                   swing_ok;

  for (genvar k = 0; k < SWING_STEPS; k++) begin : g_code
    assign code_hit[k] = (wr_data == WORD_W'(k * SWING_STEP));
  end
  assign swing_ok = |code_hit;

  always_comb begin
    ctrl_n  = ctrl_q;
    tap0_n  = tap0_q;
    tap1_n  = tap1_q;
    swing_n = swing_q;
    if (ctrl_q[SRST_BIT]) begin
      ctrl_n  = '0;
      tap0_n  = '0;
      tap1_n  = '0;
      swing_n = DEF_SWING;
    end else if (wr_en) begin
      case (reg_addr)
        RA_CTRL:  ctrl_n = wr_data & CTRL_WMASK;
        RA_TAP0:  tap0_n = wr_data;
        RA_TAP1:  tap1_n = wr_data;
        RA_SWING: if (swing_ok) swing_n = wr_data;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  rd_data = ctrl_q;
      RA_TAP0:  rd_data = tap0_q;
      RA_TAP1:  rd_data = tap1_q;
      RA_SWING: rd_data = swing_q;
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tap0_q  <= '0;
      tap1_q  <= '0;
      swing_q <= DEF_SWING;
    end else begin
      ctrl_q  <= ctrl_n;
      tap0_q  <= tap0_n;
      tap1_q  <= tap1_n;
      swing_q <= swing_n;
    end
  end
endmodule

// File: rtl/mdio_c45_slave.sv
module mdio_c45_slave
  import mdio_c45_pkg::*;
#(
  parameter int unsigned DEV_ADDR     = 30,
  parameter int unsigned PREAMBLE_LEN = 32,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_en,
  input  logic [PRT_W-1:0]  port_addr,
  input  logic              mdc,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] deemph_tap0,
  output logic [WORD_W-1:0] deemph_tap1,
  output logic [WORD_W-1:0] swing_code
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              rise, fall, bit_s;
  logic [WORD_W-1:0] reg_addr, wr_data, rd_data;
  logic              wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_int_n), .mdc_i(mdc), .mdio_i(mdio_in),
    .mdc_rise(rise), .mdc_fall(fall), .mdio_bit(bit_s)
  );

  mdio_frame_engine #(.DEV_ADDR(DEV_ADDR), .PREAMBLE_LEN(PREAMBLE_LEN)) i_eng (
    .clk(clk), .rst_n(rst_int_n), .mgmt_en(mgmt_en), .port_addr(port_addr),
    .rise(rise), .fall(fall), .bit_in(bit_s), .rd_data(rd_data),
    .reg_addr(reg_addr), .wr_data(wr_data), .wr_en(wr_en),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  mdio_c45_regs i_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .ctrl_q(ctrl_word),
    .tap0_q(deemph_tap0), .tap1_q(deemph_tap1), .swing_q(swing_code)
  );
endmodule

// File: rtl/mdio_c45_slave_chk.sv
module mdio_c45_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mgmt_en,
  input logic        mdio_oe,
  input logic [15:0] ctrl_word,
  input logic [15:0] deemph_tap0,
  input logic [15:0] deemph_tap1,
  input logic [15:0] swing_code
);
  AST_SWRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[15] |=> (ctrl_word == 16'h0000 && deemph_tap0 == 16'h0000 &&
                       deemph_tap1 == 16'h0000 && swing_code == 16'h0492)); // R9

  AST_SWING_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ((swing_code % 16'h0492) == 16'h0000) && (swing_code <= 16'h1FFE)); // R10

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word & ~16'h880F) == 16'h0000); // R8

  AST_DISABLED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_en |=> !mdio_oe); // R11

  AST_DISABLED_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mgmt_en && !ctrl_word[15]) |=>
      ($stable(deemph_tap0) && $stable(deemph_tap1) && $stable(swing_code))); // R11
endmodule

bind mdio_c45_slave mdio_c45_slave_chk i_chk (.*);

// File: tb/test_mdio_c45_slave.sv
module test_mdio_c45_slave;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, mgmt_en, mdc, drv_oe, drv_val;
  logic [4:0] pa;
  wire        dut_out, dut_oe;
  wire [15:0] ctrl_w, tap0, tap1, swing;
  wire        line = dut_oe ? dut_out : (drv_oe ? drv_val : 1'b1);

  mdio_c45_slave i_mdio_c45_slave (
    .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .port_addr(pa),
    .mdc(mdc), .mdio_in(line), .mdio_out(dut_out), .mdio_oe(dut_oe),
    .ctrl_word(ctrl_w), .deemph_tap0(tap0), .deemph_tap1(tap1),
    .swing_code(swing)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;
  logic [15:0] m_ctrl, m_tap0, m_tap1, m_swing, m_addr;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic m_defaults();
    m_ctrl = 16'h0000; m_tap0 = 16'h0000; m_tap1 = 16'h0000; m_swing = 16'h0492;
  endtask

  function automatic logic [15:0] m_read(input logic [15:0] a);
    case (a)
      16'd1:   return m_ctrl;
      16'd5:   return m_tap0;
      16'd6:   return m_tap1;
      16'd49:  return m_swing;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit swing_legal(input logic [15:0] v);
    for (int k = 0; k < 8; k++) if (v == 16'(k * 1170)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_write(input logic [15:0] a, input logic [15:0] d);
    case (a)
      16'd1:  if (d[15]) m_defaults(); else m_ctrl = d & 16'h080F;
      16'd5:  m_tap0 = d;
      16'd6:  m_tap1 = d;
      16'd49: if (swing_legal(d)) m_swing = d;
      default: ;
    endcase
  endtask

  // per-clock comparison of the register outputs against the model
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk("R4/R8 ctrl_word per clock", ctrl_w, m_ctrl);
      chk("R4 deemph_tap0 per clock", tap0, m_tap0);
      chk("R4 deemph_tap1 per clock", tap1, m_tap1);
      chk("R10 swing_code per clock", swing, m_swing);
      if (!mgmt_en) chk("R11 no drive while disabled", {15'd0, dut_oe}, 16'd0);
    end
  end

  task automatic mdc_bit(input bit drive, input bit b, output bit s_oe, output bit s_val);
    @(negedge clk);
    mdc = 1'b0; drv_oe = drive; drv_val = b;
    repeat (6) @(negedge clk);
    s_oe = dut_oe; s_val = line;
    mdc = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] prt, input logic [4:0] dev,
                           input logic [15:0] wd, input int pre, output logic [15:0] rd,
                           output bit ta1_oe, output bit ta2_oe, output bit ta2_val,
                           output int data_oe);
    bit so, sv, hit;
    hit = mgmt_en && (prt == pa) && (dev == 5'd30) && (pre >= 32);
    rd = 16'h0000; data_oe = 0; ta1_oe = 1'b0; ta2_oe = 1'b0; ta2_val = 1'b1;
    for (int i = 0; i < pre; i++) mdc_bit(1'b1, 1'b1, so, sv);
    mdc_bit(1'b1, 1'b0, so, sv);
    mdc_bit(1'b1, 1'b0, so, sv);
    for (int i = 1; i >= 0; i--) mdc_bit(1'b1, op[i], so, sv);
    for (int i = 4; i >= 0; i--) mdc_bit(1'b1, prt[i], so, sv);
    for (int i = 4; i >= 0; i--) mdc_bit(1'b1, dev[i], so, sv);
    if (op[1]) begin
      mdc_bit(1'b0, 1'b1, so, sv); ta1_oe = so;
      mdc_bit(1'b0, 1'b1, so, sv); ta2_oe = so; ta2_val = sv;
      for (int i = 15; i >= 0; i--) begin
        if (i == 0) cmp_en = 1'b0;
        mdc_bit(1'b0, 1'b1, so, sv);
        rd = {rd[14:0], sv};
        data_oe += int'(so);
      end
    end else begin
      mdc_bit(1'b1, 1'b1, so, sv);
      mdc_bit(1'b1, 1'b0, so, sv);
      for (int i = 15; i >= 0; i--) begin
        if (i == 0) cmp_en = 1'b0;
        mdc_bit(1'b1, wd[i], so, sv);
      end
    end
    @(negedge clk);
    mdc = 1'b0; drv_oe = 1'b0;
    repeat (4) @(negedge clk);
    if (hit) begin
      case (op)
        2'b00: m_addr = wd;
        2'b01: m_write(m_addr, wd);
        2'b10: m_addr = m_addr + 16'd1;
        default: ;
      endcase
    end
    cmp_en = 1'b1;
  endtask

  task automatic wr_frame(input logic [15:0] d, input int pre, input logic [4:0] prt, input logic [4:0] dev);
    logic [15:0] rd; bit a, b, c; int n;
    run_frame(2'b01, prt, dev, d, pre, rd, a, b, c, n);
  endtask

  task automatic set_addr(input logic [15:0] a);
    logic [15:0] rd; bit x, y, z; int n;
    run_frame(2'b00, pa, 5'd30, a, 32, rd, x, y, z, n);
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
    set_addr(a);
    wr_frame(d, 32, pa, 5'd30);
  endtask

  // read with turnaround and data checks; hit=0 expects an undriven line
  task automatic rd_chk(input string tag, input logic [1:0] op, input logic [4:0] prt,
                        input bit expect_hit);
    logic [15:0] rd, exp; bit t1, t2, tv; int n;
    exp = m_read(m_addr);
    run_frame(op, prt, 5'd30, 16'h0000, 32, rd, t1, t2, tv, n);
    if (expect_hit) begin
      chk({tag, " read data"}, rd, exp);
      chk("R5 first turnaround undriven", {15'd0, t1}, 16'd0);
      chk("R5 second turnaround driven", {15'd0, t2}, 16'd1);
      chk("R5 second turnaround is 0", {15'd0, tv}, 16'd0);
      chk("R5 data bits driven", 16'(n), 16'd16);
    end else begin
      chk({tag, " line stays released"}, rd, 16'hFFFF);
      chk({tag, " no drive enable seen"}, 16'(n) | {15'd0, t2}, 16'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; mgmt_en = 1'b1; mdc = 1'b0; drv_oe = 1'b0; drv_val = 1'b1;
    pa = 5'b10110; m_addr = 16'h0000;
    m_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl reset", ctrl_w, 16'h0000);
    chk("R1 tap0 reset", tap0, 16'h0000);
    chk("R1 tap1 reset", tap1, 16'h0000);
    chk("R1 swing reset", swing, 16'h0492);
    chk("R1 oe reset", {15'd0, dut_oe}, 16'd0);
    cmp_en = 1'b1;

    // R4 writes, R5 reads
    wr_reg(16'd5, 16'hF224);
    wr_reg(16'd6, 16'h0D44);
    rd_chk("R4 tap1 readback", 2'b11, pa, 1'b1);
    set_addr(16'd5);
    rd_chk("R5 tap0 read", 2'b11, pa, 1'b1);
    rd_chk("R5 pointer unchanged", 2'b11, pa, 1'b1);

    // R6 post-increment across 5,6,7
    set_addr(16'd5);
    rd_chk("R6 incr read at 5", 2'b10, pa, 1'b1);
    rd_chk("R6 incr read at 6", 2'b10, pa, 1'b1);
    rd_chk("R6 R7 incr read unmapped 7", 2'b10, pa, 1'b1);
    chk("R6 pointer advanced to 8", m_addr, 16'd8);

    // R7 unmapped write discarded
    wr_reg(16'd7, 16'h1234);
    rd_chk("R7 unmapped read zero", 2'b11, pa, 1'b1);

    // R8 control mask
    wr_reg(16'd1, 16'h7FFF);
    rd_chk("R8 ctrl masked", 2'b11, pa, 1'b1);

    // R10 swing code filter
    wr_reg(16'd49, 16'h1248);
    wr_frame(16'h1249, 32, pa, 5'd30);
    rd_chk("R10 illegal code kept old", 2'b11, pa, 1'b1);
    wr_frame(16'h1FFE, 32, pa, 5'd30);
    wr_frame(16'h2490, 32, pa, 5'd30);
    rd_chk("R10 top code kept", 2'b11, pa, 1'b1);

    // R2 preamble threshold
    set_addr(16'd5);
    wr_frame(16'hAAAA, 31, pa, 5'd30);
    rd_chk("R2 short preamble ignored", 2'b11, pa, 1'b1);
    wr_frame(16'hF040, 40, pa, 5'd30);
    rd_chk("R2 long preamble accepted", 2'b11, pa, 1'b1);

    // R3 port and device filtering
    wr_frame(16'h5555, 32, pa ^ 5'b00001, 5'd30);
    wr_frame(16'h6666, 32, pa, 5'd29);
    rd_chk("R3 foreign frames ignored", 2'b11, pa, 1'b1);
    rd_chk("R3 foreign port read", 2'b11, pa ^ 5'b10000, 1'b0);

    // R11 management disabled
    mgmt_en = 1'b0;
    wr_frame(16'h0808, 32, pa, 5'd30);
    rd_chk("R11 read while disabled", 2'b11, pa, 1'b0);
    mgmt_en = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R11 write while disabled ignored", 2'b11, pa, 1'b1);

    // R9 software reset
    wr_reg(16'd6, 16'h0688);
    wr_reg(16'd1, 16'h8801);
    rd_chk("R9 ctrl reads 0 after reset", 2'b11, pa, 1'b1);
    set_addr(16'd49);
    rd_chk("R9 swing restored", 2'b11, pa, 1'b1);
    set_addr(16'd6);
    rd_chk("R9 tap1 restored", 2'b11, pa, 1'b1);
    chk("R9 tap0 port", tap0, 16'h0000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got=%h exp=%h", 16'h0000, 16'h0001);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule